// File: doc/BRIEF.md
# Operand Queue Register File

This block is the operand store of a queue-style processor core. Intermediate values live in a circular register file, and three pointers address them. Results are appended at the tail. An instruction takes its first operand at the head and its second operand at a signed distance from the head. A consume count then moves the head forward by the number of operands used.

A third pointer, the live-head, trails the head. It marks the oldest entry that may still be read. While the live-head follows the head, consumed values drop out of reach at once. A stop command freezes the live-head, so that values already consumed can be read again through negative offsets. A release command moves the live-head up to the head and frees that space.

Occupancy is counted from the live-head to the tail. Writes that would overrun the live-head are refused as a whole batch. Reads that fall outside the live window are flagged. Several results may be appended in one cycle, in port order.

Top module: `opq_regfile`

## Requirements
- R1: After reset all three pointers are equal, `empty` is 1, `full` is 0, and any enabled read reports `rd_err`.
- R2: Read port i returns the entry at head plus `rd_off` slice i, taken as an 8-bit two's complement number. An offset of 0 returns the oldest unconsumed value. Read data is combinational from the stored state.
- R3: Write ports whose `wr_en` bit is set are stored in ascending port index at consecutive entries starting at the tail, with disabled ports skipped. The tail advances by the number of enabled ports, and the data is readable from the next cycle.
- R4: `consume` advances the head by its value. A value larger than the count of unconsumed entries (tail minus head) raises `cons_err` in that cycle and leaves the head unchanged.
- R5: While the live-head is not frozen, it follows the head, so an entry is out of reach as soon as it has been consumed.
- R6: `live_stop` freezes the live-head at its current position. Consumed entries between it and the head stay readable through negative offsets until a release.
- R7: `live_release` sets the live-head to the head value that results from the same cycle's consume, and unfreezes it. If `live_stop` is also high in that cycle, the live-head moves and stays frozen at the new position.
- R8: Occupancy is tail minus live-head modulo 128, and usable capacity is 127. `empty` is high when the occupancy is 0, and `full` is high when it is 127.
- R9: If the occupancy at the start of the cycle plus the number of enabled writes exceeds 127, `wr_block` is high, no entry is written and the tail is unchanged. The check uses the live-head before any release in the same cycle.
- R10: An enabled read whose address lies outside the range from the live-head up to (not including) the tail raises `rd_err` for that port. A port that is not enabled never raises `rd_err`.
- R11: All pointer and address arithmetic wraps modulo 128 without loss of data or flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_en | input | 2 | Read enable per port |
| rd_off | input | 16 | Signed 8-bit head-relative offset per port |
| rd_data | output | 64 | 32-bit read data per port |
| rd_err | output | 2 | Read outside the live window, per port |
| wr_en | input | 4 | Write enable per port, port order is append order |
| wr_data | input | 128 | 32-bit write data per port |
| wr_block | output | 1 | Write batch refused because the capacity would be exceeded |
| consume | input | 3 | Number of entries to move the head by |
| cons_err | output | 1 | Consume count exceeds the unconsumed entries |
| live_stop | input | 1 | Freeze the live-head |
| live_release | input | 1 | Move the live-head to the head and unfreeze it |
| empty | output | 1 | No live entries |
| full | output | 1 | 127 live entries |

## Verification
The fragile overlap is a tail write arriving in the same cycle as a live-head release while the queue is at capacity. The write must still be refused, because the space freed by the release counts only from the next cycle. The bench provokes this on purpose: it fills the queue, freezes the live-head, consumes, and then drives a release together with a single write. A consume combined with negative-offset reads of frozen entries, and long wrapping traffic with random stop and release, are judged cycle by cycle against a behavioural model that keeps its own pointers and storage.

// File: rtl/opq_pkg.sv
package opq_pkg;
  // live-head behaviour
  typedef enum logic {
    LH_FOLLOW = 1'b0,
    LH_FROZEN = 1'b1
  } lh_mode_e;
endpackage

// File: rtl/opq_wr_place.sv
// Places enabled write ports at consecutive tail-relative entries.
module opq_wr_place #(
  parameter int NWR   = 4,
  parameter int PTR_W = 7,
  localparam int CNT_W = $clog2(NWR + 1)
) (
  input  logic [NWR-1:0]       wr_en,
  input  logic [PTR_W-1:0]     tail,
  output logic [NWR*PTR_W-1:0] wr_addr,
  output logic [CNT_W-1:0]     wr_cnt
);
  logic [CNT_W-1:0] rank;

  always_comb begin
    rank    = '0;
    wr_addr = '0;
    for (int w = 0; w < NWR; w++) begin
      wr_addr[w*PTR_W +: PTR_W] = tail + PTR_W'(rank);
      rank = rank + CNT_W'(wr_en[w]);
    end
    wr_cnt = rank;
  end
endmodule

// File: rtl/opq_rd_check.sv
// Head-relative address and live-window check for one read port.
module opq_rd_check #(
  parameter int PTR_W = 7,
  parameter int OFF_W = 8,
  localparam int SUM_W = (OFF_W > PTR_W) ? OFF_W : PTR_W
) (
  input  logic             en,
  input  logic [OFF_W-1:0] off,
  input  logic [PTR_W-1:0] head,
  input  logic [PTR_W-1:0] lhead,
  input  logic [PTR_W-1:0] occ,
  output logic [PTR_W-1:0] addr,
  output logic             err
);
  logic [SUM_W-1:0] off_ext;
  logic [SUM_W-1:0] sum;
  logic [PTR_W-1:0] rel;

  always_comb begin
    off_ext = SUM_W'($signed(off));
    sum     = SUM_W'(head) + off_ext;
    addr    = sum[PTR_W-1:0];
    rel     = addr - lhead;
    err     = en && (rel >= occ);
  end
endmodule

// File: rtl/opq_ptr_ctrl.sv
// Head, tail and live-head pointers with capacity and consume checks.
module opq_ptr_ctrl
  import opq_pkg::*;
#(
  parameter int PTR_W  = 7,
  parameter int CNT_W  = 3,
  parameter int CONS_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  wr_cnt,
  input  logic [CONS_W-1:0] consume,
  input  logic              live_stop,
  input  logic              live_release,
  output logic [PTR_W-1:0]  head,
  output logic [PTR_W-1:0]  tail,
  output logic [PTR_W-1:0]  lhead,
  output logic [PTR_W-1:0]  occ,
  output logic              lh_held,
  output logic              wr_block,
  output logic              cons_err,
  output logic              empty,
  output logic              full
);
  localparam int CAP = (1 << PTR_W) - 1;

  logic [PTR_W-1:0] head_q, head_d;
  logic [PTR_W-1:0] tail_q, tail_d;
  logic [PTR_W-1:0] lhead_q, lhead_d;
  lh_mode_e         mode_q, mode_d;
  logic [PTR_W-1:0] avail;
  logic [PTR_W:0]   need;
  logic             head_en, tail_en, lhead_en, mode_en;

  // next-state
  always_comb begin
    occ      = tail_q - lhead_q;
    avail    = tail_q - head_q;
    need     = {1'b0, occ} + (PTR_W+1)'(wr_cnt);
    wr_block = need > (PTR_W+1)'(CAP);
    cons_err = (PTR_W+1)'(consume) > {1'b0, avail};
    head_d   = head_q + PTR_W'(consume);
    tail_d   = tail_q + PTR_W'(wr_cnt);
    head_en  = !cons_err && (consume != '0);
    tail_en  = !wr_block && (wr_cnt != '0);

    lhead_d  = lhead_q;
    mode_d   = mode_q;
    lhead_en = 1'b0;
    mode_en  = 1'b0;
    if (live_release) begin
      lhead_d  = cons_err ? head_q : head_d;
      lhead_en = 1'b1;
      mode_d   = live_stop ? LH_FROZEN : LH_FOLLOW;
      mode_en  = 1'b1;
    end else if (live_stop) begin
      mode_d  = LH_FROZEN;
      mode_en = 1'b1;
    end else if (mode_q == LH_FOLLOW) begin
      lhead_d  = cons_err ? head_q : head_d;
      lhead_en = head_en;
    end
    empty = (occ == '0);
    full  = (occ == PTR_W'(CAP));
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      lhead_q <= '0;
      mode_q  <= LH_FOLLOW;
    end else begin
      if (head_en)  head_q  <= head_d;
      if (tail_en)  tail_q  <= tail_d;
      if (lhead_en) lhead_q <= lhead_d;
      if (mode_en)  mode_q  <= mode_d;
    end
  end

  assign head    = head_q;
  assign tail    = tail_q;
  assign lhead   = lhead_q;
  assign lh_held = (mode_q == LH_FROZEN);
endmodule

// File: rtl/opq_regfile.sv
// Produced-order operand queue register file.
module opq_regfile #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 128,
  parameter int NRD    = 2,
  parameter int NWR    = 4,
  parameter int OFF_W  = 8,
  parameter int CONS_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NRD-1:0]      rd_en,
  input  logic [NRD*OFF_W-1:0] rd_off,
  output logic [NRD*DATA_W-1:0] rd_data,
  output logic [NRD-1:0]      rd_err,
  input  logic [NWR-1:0]      wr_en,
  input  logic [NWR*DATA_W-1:0] wr_data,
  output logic                wr_block,
  input  logic [CONS_W-1:0]   consume,
  output logic                cons_err,
  input  logic                live_stop,
  input  logic                live_release,
  output logic                empty,
  output logic                full
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(NWR + 1);

  logic [1:0]           rst_sync_q;
  logic                 rst_core_n;
  logic [PTR_W-1:0]     head_q, tail_q, lhead_q, occ;
  logic                 lh_held;
  logic [NWR*PTR_W-1:0] wr_addr;
  logic [CNT_W-1:0]     wr_cnt;
  logic [PTR_W-1:0]     rd_addr [NRD];
  logic [DATA_W-1:0]    mem_q [DEPTH];

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  opq_wr_place #(.NWR(NWR), .PTR_W(PTR_W)) place_i (
    .wr_en  (wr_en),
    .tail   (tail_q),
    .wr_addr(wr_addr),
    .wr_cnt (wr_cnt)
  );

  opq_ptr_ctrl #(.PTR_W(PTR_W), .CNT_W(CNT_W), .CONS_W(CONS_W)) ptr_i (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .wr_cnt      (wr_cnt),
    .consume     (consume),
    .live_stop   (live_stop),
    .live_release(live_release),
    .head        (head_q),
    .tail        (tail_q),
    .lhead       (lhead_q),
    .occ         (occ),
    .lh_held     (lh_held),
    .wr_block    (wr_block),
    .cons_err    (cons_err),
    .empty       (empty),
    .full        (full)
  );

  // storage: data is not reset, written only when the batch is accepted
  always_ff @(posedge clk) begin
    if (!wr_block) begin
      for (int w = 0; w < NWR; w++) begin
        if (wr_en[w]) mem_q[wr_addr[w*PTR_W +: PTR_W]] <= wr_data[w*DATA_W +: DATA_W];
      end
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    opq_rd_check #(.PTR_W(PTR_W), .OFF_W(OFF_W)) chk_i (
      .en   (rd_en[r]),
      .off  (rd_off[r*OFF_W +: OFF_W]),
      .head (head_q),
      .lhead(lhead_q),
      .occ  (occ),
      .addr (rd_addr[r]),
      .err  (rd_err[r])
    );
    assign rd_data[r*DATA_W +: DATA_W] = mem_q[rd_addr[r]];
  end
endmodule

// File: rtl/opq_regfile_chk.sv
module opq_regfile_chk #(
  parameter int PTR_W = 7,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PTR_W-1:0] head,
  input logic [PTR_W-1:0] tail,
  input logic [PTR_W-1:0] lhead,
  input logic [CNT_W-1:0] wr_cnt,
  input logic             lh_held,
  input logic             wr_block,
  input logic             cons_err,
  input logic             live_stop,
  input logic             live_release,
  input logic             empty,
  input logic             full
);
  // R9
  blk_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_block |=> tail == $past(tail));
  // R3
  tail_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_block |=> tail == PTR_W'($past(tail) + PTR_W'($past(wr_cnt))));
  // R4
  cons_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cons_err |=> head == $past(head));
  // R5
  follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lh_held && !live_stop && !live_release) |=> lhead == head);
  // R6
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lh_held && !live_release) |=> $stable(lhead));
  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_release |=> lhead == head);
  // R8
  flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));
endmodule

bind opq_regfile opq_regfile_chk #(.PTR_W(PTR_W), .CNT_W(CNT_W)) sva_i (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .head        (head_q),
  .tail        (tail_q),
  .lhead       (lhead_q),
  .wr_cnt      (wr_cnt),
  .lh_held     (lh_held),
  .wr_block    (wr_block),
  .cons_err    (cons_err),
  .live_stop   (live_stop),
  .live_release(live_release),
  .empty       (empty),
  .full        (full)
);

// File: tb/opq_regfile_tb_top.sv
module opq_regfile_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   rd_en = '0;
  logic [15:0]  rd_off = '0;
  logic [63:0]  rd_data;
  logic [1:0]   rd_err;
  logic [3:0]   wr_en = '0;
  logic [127:0] wr_data = '0;
  logic         wr_block;
  logic [2:0]   consume = '0;
  logic         cons_err;
  logic         live_stop = 1'b0;
  logic         live_release = 1'b0;
  logic         empty, full;

  int n_checks = 0;
  int n_errs = 0;
  bit done = 1'b0;
  string phase = "R1";

  // reference model
  logic [31:0] m_mem [128];
  int m_h = 0, m_t = 0, m_lh = 0;
  bit m_hold = 1'b0;
  int seq = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  opq_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_off(rd_off), .rd_data(rd_data),
    .rd_err(rd_err), .wr_en(wr_en), .wr_data(wr_data), .wr_block(wr_block),
    .consume(consume), .cons_err(cons_err), .live_stop(live_stop),
    .live_release(live_release), .empty(empty), .full(full)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s (phase %s): actual %h expected %h", tag, phase, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  endtask

  // one clock: drive at negedge, compare before posedge, advance model at posedge
  task automatic cyc(input logic [3:0] we, input int c, input bit s, input bit r,
                     input bit e0, input int o0, input bit e1, input int o1);
    int occ, avail, n, addr, k, hn;
    bit wblk, cerr, e_err;
    bit ens [2];
    int offs [2];
    @(negedge clk);
    ens[0] = e0; ens[1] = e1; offs[0] = o0; offs[1] = o1;
    wr_en = we;
    for (int w = 0; w < 4; w++) begin
      seq++;
      wr_data[w*32 +: 32] = 32'hA500_0000 + 32'(seq);
    end
    consume = 3'(c);
    live_stop = s;
    live_release = r;
    rd_en = {e1, e0};
    rd_off = {8'(o1), 8'(o0)};
    #3;
    occ = (m_t - m_lh) & 127;
    avail = (m_t - m_h) & 127;
    n = 0;
    for (int w = 0; w < 4; w++) if (we[w]) n++;
    wblk = (occ + n) > 127;
    cerr = c > avail;
    chk("R9 wr_block", 32'(wr_block), 32'(wblk));
    chk("R4 cons_err", 32'(cons_err), 32'(cerr));
    chk("R8 empty", 32'(empty), 32'(occ == 0));
    chk("R8 full", 32'(full), 32'(occ == 127));
    for (int i = 0; i < 2; i++) begin
      addr = (m_h + offs[i]) & 127;
      e_err = ens[i] && (((addr - m_lh) & 127) >= occ);
      chk("R10 rd_err", 32'(rd_err[i]), 32'(e_err));
      if (ens[i] && !e_err) chk("R2 rd_data", rd_data[i*32 +: 32], m_mem[addr]);
    end
    @(posedge clk);
    if (!wblk) begin
      k = 0;
      for (int w = 0; w < 4; w++) begin
        if (we[w]) begin
          m_mem[(m_t + k) & 127] = wr_data[w*32 +: 32];
          k++;
        end
      end
      m_t = (m_t + n) & 127;
    end
    hn = cerr ? m_h : ((m_h + c) & 127);
    if (r) begin
      m_lh = hn;
      m_hold = s;
    end else if (s) m_hold = 1'b1;
    else if (!m_hold) m_lh = hn;
    m_h = hn;
  endtask

  task automatic idle(); cyc(4'b0000, 0, 0, 0, 0, 0, 0, 0); endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    // R1: reset state, empty window
    phase = "R1";
    cyc(4'b0000, 0, 0, 0, 1, 0, 1, -1);
    // R3: sparse then full write batches
    phase = "R3";
    cyc(4'b1011, 0, 0, 0, 0, 0, 0, 0);
    cyc(4'b1111, 0, 0, 0, 1, 0, 1, 2);
    cyc(4'b0100, 0, 0, 0, 1, 6, 1, 7);
    // R2: head-relative reads with positive offsets
    phase = "R2";
    cyc(4'b0000, 0, 0, 0, 1, 1, 1, 3);
    cyc(4'b0000, 0, 0, 0, 1, 5, 1, 8);
    // R4: consume, over-consume
    phase = "R4";
    cyc(4'b0000, 2, 0, 0, 1, 0, 1, 1);
    cyc(4'b0000, 7, 0, 0, 1, 0, 0, 0);
    // R5: consumed data out of reach while following
    phase = "R5";
    cyc(4'b0000, 1, 0, 0, 1, -1, 1, 0);
    cyc(4'b0000, 0, 0, 0, 1, -1, 1, -3);
    // R6: freeze, consume, reuse with negative offsets
    phase = "R6";
    cyc(4'b0000, 0, 1, 0, 0, 0, 0, 0);
    cyc(4'b0001, 2, 0, 0, 1, 0, 1, 1);
    cyc(4'b0000, 1, 0, 0, 1, -1, 1, -2);
    cyc(4'b0000, 0, 0, 0, 1, -3, 1, -4);
    // R7: release, then release together with stop
    phase = "R7";
    cyc(4'b0000, 1, 0, 1, 1, -1, 1, 0);
    cyc(4'b0000, 0, 0, 0, 1, -1, 1, 0);
    cyc(4'b0000, 1, 1, 1, 0, 0, 0, 0);
    cyc(4'b0000, 1, 0, 0, 1, -1, 1, -2);
    cyc(4'b0000, 0, 0, 1, 1, -1, 1, 0);
    // R9 / R8: fill to capacity
    phase = "R9";
    for (int i = 0; i < 34; i++) cyc(4'b1111, 0, 0, 0, 1, 0, 1, -1);
    for (int i = 0; i < 4; i++) cyc(4'b0010, 0, 0, 0, 1, 126, 0, 0);
    cyc(4'b0000, 0, 1, 0, 0, 0, 0, 0);
    cyc(4'b0001, 3, 0, 0, 1, -3, 1, 0);
    cyc(4'b1000, 0, 0, 1, 1, -1, 1, 0);
    cyc(4'b1111, 0, 0, 0, 1, -1, 1, 0);
    cyc(4'b0001, 0, 0, 0, 0, 0, 0, 0);
    // R8: drain to empty
    phase = "R8";
    for (int i = 0; i < 50; i++) cyc(4'b0000, 3, 0, 0, 1, 0, 1, 2);
    idle();
    // R11: wrapping random traffic with freeze and release
    phase = "R11";
    for (int i = 0; i < 1500; i++) begin
      int c, o0, o1;
      logic [3:0] we;
      bit s, r;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      we = lfsr[3:0];
      c = int'(lfsr[6:4]);
      if (c > 5) c = c - 3;
      s = (lfsr[11:8] == 4'h3);
      r = (lfsr[11:8] == 4'h9) || (lfsr[11:8] == 4'hC);
      o0 = int'(lfsr[15:12]) - 8;
      o1 = 7 - int'(lfsr[14:11]);
      cyc(we, c, s, r, lfsr[7], o0, 1, o1);
    end
    idle();
    summary();
  end
endmodule